// File: doc/BRIEF.md
# Key-Locked Indexed Configuration Port

This block sits on a simple 8-bit host I/O bus and fronts a small chipset configuration register file. The host first writes a register number to an index port. It then reads or writes that register through a data port. The index it wrote stays in place, so several data accesses can follow one index write.

Access to the register file is guarded by a lock register that lives inside the block. Storing a fixed key value in the lock register opens the path. Storing any other value closes it. The lock register can always be written, so software can reopen the path at any time. While the path is closed, reads of the data port return all ones and writes are discarded. The block shows each accepted register-file write on a strobe with its index and data. It also shows the current index together with the data stored at that index. Only a small scratch array is modelled behind the port.

Top module: `cfg_keylock_port`

## Requirements
- R1: After reset the path is closed (lock read returns 0x00) and the index register holds 0x00.
- R2: A write to I/O address 0x22 loads the index register in either lock state. A read of 0x22 returns the index. The index keeps its value across any number of data-port (0x23) accesses.
- R3: A data-port write of 0xC5 while the index is 0x03 opens the path, in either lock state. A data-port read at index 0x03 then returns 0x01.
- R4: A data-port write at index 0x03 of any value other than 0xC5 closes the path. A data-port read at index 0x03 then returns 0x00.
- R5: While the path is closed, data-port writes at any index other than 0x03 leave rf_we low and do not change the scratch contents.
- R6: While the path is closed, data-port reads at any index other than 0x03 return 0xFF.
- R7: While the path is open, a data-port write at an index other than 0x03 raises rf_we in that same cycle, with rf_idx equal to the index and rf_wdata equal to the written byte. If the index lies in the scratch window 0x40 to 0x4F, the byte is stored there and later data-port reads at that index return it.
- R8: While the path is open, data-port reads at indices outside the scratch window (other than 0x03) return 0x00, even after writes to them.
- R9: Accesses to I/O addresses other than 0x22 and 0x23 change no state and read as 0x00. io_rdata is 0x00 whenever io_rd is low. When io_wr and io_rd are both high, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_wr | input | 1 | Host write strobe, one access per cycle |
| io_rd | input | 1 | Host read strobe |
| io_rdata | output | 8 | Host read data, combinational in the read cycle |
| rf_we | output | 1 | Register-file write strobe |
| rf_idx | output | 8 | Current index (write and read index) |
| rf_wdata | output | 8 | Register-file write data |
| rf_rdata | output | 8 | Scratch content at the current index |

## Verification
The hardest case to reach from the ports is a closed path that hides stored data. This covers data that was written while the path was open, then overwritten while it was closed, and then must be seen unchanged once the path reopens. The bench first fills every index with a pattern while the path is open. It then closes the path and sweeps all 256 indices with writes and reads. Finally it reopens the path and reads the whole window back. The key is also swept over all 256 values from both lock states, so that only 0xC5 opens the path.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_IDX_WR,
    ACC_IDX_RD,
    ACC_DAT_WR,
    ACC_DAT_RD
  } acc_kind_e;
endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
  import cfg_port_pkg::*;
#(
  parameter int          AW        = 8,
  parameter logic [AW-1:0] IDX_PORT  = 8'h22,
  parameter logic [AW-1:0] DATA_PORT = 8'h23
) (
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  output acc_kind_e     kind
);
  // a write takes precedence when both strobes are high
  always_comb begin
    kind = ACC_NONE;
    if (wr) begin
      if (addr == IDX_PORT)       kind = ACC_IDX_WR;
      else if (addr == DATA_PORT) kind = ACC_DAT_WR;
    end else if (rd) begin
      if (addr == IDX_PORT)       kind = ACC_IDX_RD;
      else if (addr == DATA_PORT) kind = ACC_DAT_RD;
    end
  end
endmodule

// File: rtl/cfg_port_lock.sv
module cfg_port_lock #(
  parameter int           DW       = 8,
  parameter logic [DW-1:0] LOCK_IDX = 8'h03,
  parameter logic [DW-1:0] KEY      = 8'hC5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dat_wr,
  input  logic [DW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic          is_lock_idx,
  output logic          open_q
);
  assign is_lock_idx = (idx == LOCK_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n)                        open_q <= 1'b0;
    else if (dat_wr && is_lock_idx)    open_q <= (wdata == KEY);
  end
endmodule

// File: rtl/cfg_port_scratch.sv
module cfg_port_scratch #(
  parameter int           DW    = 8,
  parameter logic [DW-1:0] BASE  = 8'h40,
  parameter int           DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]    offset;
  logic             in_win;
  logic [SEL_W-1:0] sel;
  logic [DW-1:0]    cells [DEPTH];

  assign offset = idx - BASE;
  assign in_win = (idx >= BASE) && ({1'b0, offset} < (DW+1)'(DEPTH));
  assign sel    = offset[SEL_W-1:0];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)                                     cells[g] <= '0;
      else if (we && in_win && sel == SEL_W'(g))      cells[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (in_win) rdata = cells[sel];
  end
endmodule

// File: rtl/cfg_keylock_port.sv
module cfg_keylock_port
  import cfg_port_pkg::*;
#(
  parameter logic [7:0] IDX_PORT  = 8'h22,
  parameter logic [7:0] DATA_PORT = 8'h23,
  parameter logic [7:0] LOCK_IDX  = 8'h03,
  parameter logic [7:0] KEY       = 8'hC5,
  parameter logic [7:0] RF_BASE   = 8'h40,
  parameter int         RF_DEPTH  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] io_addr,
  input  logic [7:0] io_wdata,
  input  logic       io_wr,
  input  logic       io_rd,
  output logic [7:0] io_rdata,
  output logic       rf_we,
  output logic [7:0] rf_idx,
  output logic [7:0] rf_wdata,
  output logic [7:0] rf_rdata
);
  localparam logic [7:0] CLOSED_RD = 8'hFF;

  acc_kind_e  kind;
  logic [7:0] cur_idx;
  logic       lock_open;
  logic       at_lock;
  logic [7:0] scr_rdata;

  cfg_port_decode #(.AW(8), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT)) u_dec (
    .addr(io_addr), .wr(io_wr), .rd(io_rd), .kind(kind)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                 cur_idx <= '0;
    else if (kind == ACC_IDX_WR) cur_idx <= io_wdata;
  end

  cfg_port_lock #(.DW(8), .LOCK_IDX(LOCK_IDX), .KEY(KEY)) u_lock (
    .clk(clk), .rst_n(rst_n), .dat_wr(kind == ACC_DAT_WR), .idx(cur_idx),
    .wdata(io_wdata), .is_lock_idx(at_lock), .open_q(lock_open)
  );

  assign rf_we    = (kind == ACC_DAT_WR) && lock_open && !at_lock;
  assign rf_idx   = cur_idx;
  assign rf_wdata = io_wdata;

  cfg_port_scratch #(.DW(8), .BASE(RF_BASE), .DEPTH(RF_DEPTH)) u_scr (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .idx(cur_idx),
    .wdata(io_wdata), .rdata(scr_rdata)
  );

  assign rf_rdata = scr_rdata;

  always_comb begin
    io_rdata = '0;
    case (kind)
      ACC_IDX_RD: io_rdata = cur_idx;
      ACC_DAT_RD: begin
        if (at_lock)         io_rdata = {7'd0, lock_open};
        else if (!lock_open) io_rdata = CLOSED_RD;
        else                 io_rdata = scr_rdata;
      end
      default:    io_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfg_keylock_port_chk.sv
module cfg_keylock_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] io_addr,
  input logic [7:0] io_wdata,
  input logic       io_wr,
  input logic       io_rd,
  input logic [7:0] io_rdata,
  input logic       rf_we,
  input logic [7:0] rf_idx,
  input logic       lock_open
);
  // R2
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 8'h22) |=> (rf_idx == $past(io_wdata)));

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_addr == 8'h22) |=> $stable(rf_idx));

  // R3
  open_by_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_open) |-> $past(io_wr && io_addr == 8'h23 && rf_idx == 8'h03 && io_wdata == 8'hC5));

  // R4
  close_by_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 8'h23 && rf_idx == 8'h03 && io_wdata != 8'hC5) |=> !lock_open);

  // R5
  no_strobe_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> lock_open);

  // R6
  closed_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_wr && io_rd && io_addr == 8'h23 && rf_idx != 8'h03 && !lock_open) |-> io_rdata == 8'hFF);

  // R9
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == 8'h00);
endmodule

bind cfg_keylock_port cfg_keylock_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
  .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .rf_we(rf_we),
  .rf_idx(rf_idx), .lock_open(lock_open)
);

// File: tb/tb_cfg_keylock_port.sv
module tb_cfg_keylock_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] io_addr = '0, io_wdata = '0;
  logic       io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_rdata, rf_idx, rf_wdata, rf_rdata;
  logic       rf_we;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic       seen_we;
  logic [7:0] seen_idx, seen_wd;

  always #2 clk = ~clk;

  cfg_keylock_port dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .rf_we(rf_we),
    .rf_idx(rf_idx), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    #1;
    seen_we = rf_we; seen_idx = rf_idx; seen_wd = rf_wdata;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 v = io_rdata;
    @(posedge clk); #1;
    io_rd = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  function automatic bit in_win(input int i);
    return (i >= 8'h40) && (i < 8'h50);
  endfunction

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(8'h22, v); chk("R1 index", v, 8'h00);
    chk("R9 idle rdata", io_rdata, 8'h00);
    wr(8'h22, 8'h03);
    rd(8'h23, v); chk("R1 lock closed", v, 8'h00);

    // R3 / R4 key sweep from both lock states
    for (int k = 0; k < 256; k++) begin
      wr(8'h23, 8'h00);
      wr(8'h23, 8'(k));
      rd(8'h23, v); chk("R3 R4 key from closed", v, (k == 8'hC5) ? 8'h01 : 8'h00);
      wr(8'h23, 8'hC5);
      wr(8'h23, 8'(k));
      rd(8'h23, v); chk("R3 R4 key from open", v, (k == 8'hC5) ? 8'h01 : 8'h00);
    end

    // R7 open fill of every index
    wr(8'h23, 8'hC5);
    for (int i = 0; i < 256; i++) begin
      if (i == 3) continue;
      wr(8'h22, 8'(i));
      wr(8'h23, pat(i));
      chk("R7 strobe", {7'd0, seen_we}, 8'h01);
      chk("R7 strobe idx", seen_idx, 8'(i));
      chk("R7 strobe data", seen_wd, pat(i));
    end
    for (int i = 0; i < 256; i++) begin
      if (i == 3) continue;
      wr(8'h22, 8'(i));
      rd(8'h23, v);
      if (in_win(i)) chk("R7 readback", v, pat(i));
      else           chk("R8 outside window", v, 8'h00);
    end

    // R5 / R6 closed sweep
    wr(8'h22, 8'h03); wr(8'h23, 8'h00);
    for (int i = 0; i < 256; i++) begin
      wr(8'h22, 8'(i));
      if (i == 3) begin
        rd(8'h23, v); chk("R4 lock read closed", v, 8'h00);
        continue;
      end
      wr(8'h23, 8'h33);
      chk("R5 no strobe", {7'd0, seen_we}, 8'h00);
      rd(8'h23, v); chk("R6 closed read", v, 8'hFF);
      rd(8'h22, v); chk("R2 index held", v, 8'(i));
    end

    // R5 contents unchanged after reopening
    wr(8'h22, 8'h03); wr(8'h23, 8'hC5);
    for (int i = 8'h40; i < 8'h50; i++) begin
      wr(8'h22, 8'(i));
      rd(8'h23, v); chk("R5 contents kept", v, pat(i));
      chk("R7 rf_rdata", rf_rdata, pat(i));
    end

    // R2 index survives many data accesses
    wr(8'h22, 8'h45);
    for (int n = 0; n < 8; n++) wr(8'h23, 8'(n));
    rd(8'h22, v); chk("R2 index after data writes", v, 8'h45);
    rd(8'h23, v); chk("R7 last write kept", v, 8'h07);

    // R9 foreign addresses and simultaneous strobes
    wr(8'h50, 8'h11);
    wr(8'h21, 8'h99);
    rd(8'h22, v); chk("R9 index untouched", v, 8'h45);
    rd(8'h50, v); chk("R9 foreign read", v, 8'h00);
    @(negedge clk);
    io_addr = 8'h22; io_wdata = 8'h47; io_wr = 1'b1; io_rd = 1'b1;
    #1 chk("R9 both strobes rdata", io_rdata, 8'h00);
    @(posedge clk); #1 io_wr = 1'b0; io_rd = 1'b0;
    rd(8'h22, v); chk("R9 write wins", v, 8'h47);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule